// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-facing control plane of an address translation unit. Software drives it over a simple bus where each access completes in one cycle. Through it, software picks the operating mode: translating, holding traffic, or off. It also sets the page table base and a configuration word, and it issues full and per-page translation cache flushes. The translation datapath reports faults as a type code with an address. The block records each fault, keeps the faulting address, raises a level interrupt, and holds traffic until software acknowledges the fault.

The hold mode stops traffic at once. A status flag then reports when in-flight requests have drained. A fault forces the hold mode with traffic already stopped. Software clears the fault bits and then writes the run code to resume. Faults fall into four address capture registers: page faults, write-channel faults, read-channel faults and bus errors. Each capture register keeps the first address of its group until every fault bit of that group has been cleared.

Top module: `tu_ctrl_regs`

## Requirements
- R1: After reset the unit is off. irq, stall, xlat_en, flush_all and flush_entry are 0. Control (0x00), status (0x08) and interrupt status (0x18) read 0.
- R2: Writing 0x5 to control (0x00) selects run mode: xlat_en=1 and stall=0. Writing 0x0 selects off mode: both outputs are 0. Control reads back 0x5, 0x7 or 0x0 for the current mode. A write of any other value leaves the mode unchanged.
- R3: Writing 0x7 to control selects hold mode, and stall=1 from the next cycle. Status bit 0 (0x08) reads 1 from the second clock edge after the edge that took the write. The bit reads 0 in any other mode. A repeated 0x7 write while in hold does not restart the drain.
- R4: An accepted fault of type t (0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection) sets bit t of interrupt status (0x18). irq is 1 whenever any status bit is set.
- R5: An accepted fault puts the unit in hold mode, with status bit 0 reading 1 in the next cycle. A fault wins over a control write in the same cycle.
- R6: Writing a mask to the clear register (0x1C) clears the status bits set in wdata[7:0]. A fault of the same type in the same cycle leaves its bit set.
- R7: Fault addresses are captured by group. Type 0 goes to 0x24. Types 2, 6 and 7 go to 0x28. Types 1, 4 and 5 go to 0x2C. Type 3 goes to 0x30. A register loads only when no status bit of its group is still set after that cycle's clear, so the first address is kept.
- R8: A fault presented while the unit is off is ignored. No status bit, capture register or mode changes.
- R9: A write to 0x0C with wdata[0]=1 gives a one-cycle flush_all pulse in the next cycle. A write to 0x10 with wdata[0]=1 gives a one-cycle flush_entry pulse, and flush_page takes wdata[31:12]. Both registers read 0.
- R10: Configuration (0x04) and table base (0x14) are read/write and drive cfg_word and tbl_base. Version (0x34) reads the major version in bits [31:28]. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, 0 when not selected |
| flt_valid | input | 1 | Fault reported by the datapath |
| flt_type | input | 3 | Fault type code |
| flt_addr | input | 32 | Faulting address |
| irq | output | 1 | Level fault interrupt |
| stall | output | 1 | Traffic hold request |
| xlat_en | output | 1 | Translation enabled |
| tbl_base | output | 32 | Page table base |
| cfg_word | output | 32 | Configuration word |
| flush_all | output | 1 | Full flush pulse |
| flush_entry | output | 1 | Single-page flush pulse |
| flush_page | output | 20 | Page number for the single-page flush |

## Verification
Register writes, fault captures, mode changes and flush pulses all show up one clock edge after the edge that samples them. The exception is the drain flag, which comes two edges after a hold write but one edge after a fault. Reads are combinational and are checked within the cycle in which the address is driven. The bench updates its reference model at the same edge the design uses and compares every output and the read data half a cycle later. Explicit checks are made one nanosecond after each edge, which keeps every sample clear of the active edge.

// File: rtl/tu_pkg.sv
// Shared constants and types for the translation unit control registers.
// Assumes byte offsets that fit in 8 bits and a fixed set of eight fault types.
package tu_pkg;
    localparam int NFAULT = 8;
    localparam int TYPE_W = 3;
    localparam int NGRP   = 4;

    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_CFG   = 'h04;
    localparam int OFF_STAT  = 'h08;
    localparam int OFF_FALL  = 'h0C;
    localparam int OFF_FENT  = 'h10;
    localparam int OFF_BASE  = 'h14;
    localparam int OFF_ISTAT = 'h18;
    localparam int OFF_ICLR  = 'h1C;
    localparam int OFF_CAP0  = 'h24;
    localparam int OFF_VER   = 'h34;

    localparam logic [31:0] CODE_RUN  = 32'h5;
    localparam logic [31:0] CODE_HOLD = 32'h7;
    localparam logic [31:0] CODE_OFF  = 32'h0;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RUN  = 2'd1,
        MODE_HOLD = 2'd2
    } mode_t;

    // Fault types per capture group: page, write channel, read channel, bus error
    localparam logic [NFAULT-1:0] GRP_MASK [NGRP] = '{8'h01, 8'hC4, 8'h32, 8'h08};
endpackage

// File: rtl/tu_mode_ctrl.sv
// Operating mode state machine: off, run and hold, with a drain counter.
// Assumes ctrl_wr is a single-cycle write strobe and fault_acc is already
// gated by the unit not being off. A fault wins over a control write.
module tu_mode_ctrl
    import tu_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int DRAIN_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_val,
    input  logic              fault_acc,
    output mode_t             mode,
    output logic              hold_done
);
    localparam int CNT_W = (DRAIN_CYCLES < 1) ? 1 : $clog2(DRAIN_CYCLES + 1);

    logic [CNT_W-1:0] drain_cnt;

    // Mode and drain counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_OFF;
            drain_cnt <= '0;
        end else if (fault_acc) begin
            mode      <= MODE_HOLD;
            drain_cnt <= '0;
        end else if (ctrl_wr && ctrl_val == DATA_W'(CODE_RUN)) begin
            mode      <= MODE_RUN;
            drain_cnt <= '0;
        end else if (ctrl_wr && ctrl_val == DATA_W'(CODE_OFF)) begin
            mode      <= MODE_OFF;
            drain_cnt <= '0;
        end else if (ctrl_wr && ctrl_val == DATA_W'(CODE_HOLD) && mode != MODE_HOLD) begin
            mode      <= MODE_HOLD;
            drain_cnt <= CNT_W'(DRAIN_CYCLES);
        end else if (mode == MODE_HOLD && drain_cnt != '0) begin
            drain_cnt <= drain_cnt - 1'b1;
        end
    end

    // Drain completes once the counter has run out in hold mode
    always_comb hold_done = (mode == MODE_HOLD) && (drain_cnt == '0);
endmodule

// File: rtl/tu_fault_log.sv
// Fault status bits and grouped fault address capture.
// Assumes fault_acc is qualified upstream; a set beats a clear of the same bit.
module tu_fault_log
    import tu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fault_acc,
    input  logic [TYPE_W-1:0]            fault_type,
    input  logic [DATA_W-1:0]            fault_addr,
    input  logic                         clr_wr,
    input  logic [NFAULT-1:0]            clr_bits,
    output logic [NFAULT-1:0]            status,
    output logic [NGRP-1:0][DATA_W-1:0]  cap_addr
);
    logic [NFAULT-1:0] set_vec;
    logic [NFAULT-1:0] keep_vec;

    // One-hot set vector and surviving bits after this cycle's clear
    always_comb begin
        set_vec  = fault_acc ? (NFAULT'(1) << fault_type) : '0;
        keep_vec = status & ~(clr_wr ? clr_bits : '0);
    end

    for (genvar i = 0; i < NFAULT; i++) begin : g_stat
        // Status bit: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) status[i] <= 1'b0;
            else        status[i] <= set_vec[i] | keep_vec[i];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_cap
        // Capture the address only when the group has no bit still pending
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap_addr[g] <= '0;
            else if ((set_vec & GRP_MASK[g]) != '0 && (keep_vec & GRP_MASK[g]) == '0)
                cap_addr[g] <= fault_addr;
        end
    end
endmodule

// File: rtl/tu_cmd_regs.sv
// Plain configuration registers and flush command pulses.
// Assumes write strobes are single-cycle and decoded by the parent.
module tu_cmd_regs #(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wr,
    input  logic                         base_wr,
    input  logic                         fall_wr,
    input  logic                         fent_wr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            cfg_word,
    output logic [DATA_W-1:0]            tbl_base,
    output logic                         flush_all,
    output logic                         flush_entry,
    output logic [DATA_W-PAGE_SHIFT-1:0] flush_page
);
    // Configuration and table base storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_word <= '0;
            tbl_base <= '0;
        end else begin
            if (cfg_wr)  cfg_word <= wdata;
            if (base_wr) tbl_base <= wdata;
        end
    end

    // Flush pulses last one cycle; the page number holds between commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_page  <= '0;
        end else begin
            flush_all   <= fall_wr & wdata[0];
            flush_entry <= fent_wr & wdata[0];
            if (fent_wr && wdata[0])
                flush_page <= wdata[DATA_W-1:PAGE_SHIFT];
        end
    end
endmodule

// File: rtl/tu_ctrl_regs.sv
// Top of the translation unit control register block: bus decode, read mux,
// mode control, fault log and command registers. Reads are combinational;
// writes take effect at the sampling edge. Assumes ADDR_W >= 8.
module tu_ctrl_regs
    import tu_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 32,
    parameter int PAGE_SHIFT   = 12,
    parameter int DRAIN_CYCLES = 2,
    parameter int VER_MAJOR    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         flt_valid,
    input  logic [2:0]                   flt_type,
    input  logic [DATA_W-1:0]            flt_addr,
    output logic                         irq,
    output logic                         stall,
    output logic                         xlat_en,
    output logic [DATA_W-1:0]            tbl_base,
    output logic [DATA_W-1:0]            cfg_word,
    output logic                         flush_all,
    output logic                         flush_entry,
    output logic [DATA_W-PAGE_SHIFT-1:0] flush_page
);
    logic                        wr_stb;
    logic                        fault_acc;
    mode_t                       mode;
    logic                        hold_done;
    logic [NFAULT-1:0]           fault_stat;
    logic [NGRP-1:0][DATA_W-1:0] cap_addr;

    // Write strobe and fault qualification
    always_comb begin
        wr_stb    = bus_sel & bus_wr;
        fault_acc = flt_valid && (mode != MODE_OFF);
    end

    tu_mode_ctrl #(
        .DATA_W      (DATA_W),
        .DRAIN_CYCLES(DRAIN_CYCLES)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (wr_stb && bus_addr == ADDR_W'(OFF_CTRL)),
        .ctrl_val (bus_wdata),
        .fault_acc(fault_acc),
        .mode     (mode),
        .hold_done(hold_done)
    );

    tu_fault_log #(
        .DATA_W(DATA_W)
    ) u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_acc (fault_acc),
        .fault_type(flt_type),
        .fault_addr(flt_addr),
        .clr_wr    (wr_stb && bus_addr == ADDR_W'(OFF_ICLR)),
        .clr_bits  (bus_wdata[NFAULT-1:0]),
        .status    (fault_stat),
        .cap_addr  (cap_addr)
    );

    tu_cmd_regs #(
        .DATA_W    (DATA_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (wr_stb && bus_addr == ADDR_W'(OFF_CFG)),
        .base_wr    (wr_stb && bus_addr == ADDR_W'(OFF_BASE)),
        .fall_wr    (wr_stb && bus_addr == ADDR_W'(OFF_FALL)),
        .fent_wr    (wr_stb && bus_addr == ADDR_W'(OFF_FENT)),
        .wdata      (bus_wdata),
        .cfg_word   (cfg_word),
        .tbl_base   (tbl_base),
        .flush_all  (flush_all),
        .flush_entry(flush_entry),
        .flush_page (flush_page)
    );

    // Mode and interrupt outputs
    always_comb begin
        xlat_en = (mode == MODE_RUN);
        stall   = (mode == MODE_HOLD);
        irq     = |fault_stat;
    end

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFF_CTRL):  bus_rdata = (mode == MODE_RUN)  ? DATA_W'(CODE_RUN)  :
                                                (mode == MODE_HOLD) ? DATA_W'(CODE_HOLD) :
                                                                      DATA_W'(CODE_OFF);
                ADDR_W'(OFF_CFG):   bus_rdata = cfg_word;
                ADDR_W'(OFF_STAT):  bus_rdata = DATA_W'(hold_done);
                ADDR_W'(OFF_BASE):  bus_rdata = tbl_base;
                ADDR_W'(OFF_ISTAT): bus_rdata = DATA_W'(fault_stat);
                ADDR_W'(OFF_VER):   bus_rdata = DATA_W'(VER_MAJOR) << (DATA_W - 4);
                default: begin
                    for (int g = 0; g < NGRP; g++)
                        if (bus_addr == ADDR_W'(OFF_CAP0 + 4 * g))
                            bus_rdata = cap_addr[g];
                end
            endcase
        end
    end
endmodule

// File: rtl/tu_ctrl_regs_chk.sv
// Temporal checks on the control register block, bound to the top module.
// Assumes the default offsets and the run/hold/off codes of the package.
module tu_ctrl_regs_chk
    import tu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              flt_valid,
    input logic              irq,
    input logic              stall,
    input logic              xlat_en,
    input logic              flush_all,
    input logic              hold_done,
    input logic [NFAULT-1:0] fault_stat
);
    logic wr;
    always_comb wr = bus_sel & bus_wr;

    // R2: run code from any mode enables translation without holding
    p_run_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata == DATA_W'(CODE_RUN) && !flt_valid
        |=> xlat_en && !stall);

    // R3: a hold write from run stalls at once but the drain is not yet done
    p_hold_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_CTRL) && bus_wdata == DATA_W'(CODE_HOLD) && xlat_en && !flt_valid
        |=> stall && !hold_done);

    // R5: an accepted fault stops traffic, completes the hold and raises irq
    p_fault_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && (xlat_en || stall) |=> stall && hold_done && irq);

    // R6: clearing every bit with no new fault drops the interrupt
    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && bus_addr == ADDR_W'(OFF_ICLR) && bus_wdata[NFAULT-1:0] == '1 && !flt_valid
        |=> !irq);

    // R8: faults while off do not touch the status bits
    p_off_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !xlat_en && !stall && !wr |=> $stable(fault_stat));

    // R9: a full flush pulse always follows a flush command
    p_flush_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> $past(wr && bus_addr == ADDR_W'(OFF_FALL) && bus_wdata[0]));
endmodule

bind tu_ctrl_regs tu_ctrl_regs_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flt_valid (flt_valid),
    .irq       (irq),
    .stall     (stall),
    .xlat_en   (xlat_en),
    .flush_all (flush_all),
    .hold_done (hold_done),
    .fault_stat(fault_stat)
);

// File: tb/tb_tu_ctrl_regs.sv
// Bench for tu_ctrl_regs: a behavioural reference model is stepped on every
// rising edge and compared with all outputs on every falling edge, plus
// directed checks one nanosecond after edges.
module tb_tu_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        irq, stall, xlat_en, flush_all, flush_entry;
    logic [31:0] tbl_base, cfg_word;
    logic [19:0] flush_page;

    always #4 clk = ~clk;   // 125 MHz

    tu_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
        .irq(irq), .stall(stall), .xlat_en(xlat_en), .tbl_base(tbl_base),
        .cfg_word(cfg_word), .flush_all(flush_all), .flush_entry(flush_entry),
        .flush_page(flush_page)
    );

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state: mode 0 off, 1 run, 2 hold
    int          m_mode, m_cnt;
    logic [7:0]  m_stat;
    logic [31:0] m_cap [4];
    logic [31:0] m_cfg, m_base;
    logic        m_fa, m_fe;
    logic [19:0] m_page;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Capture group: 0 page, 1 write channel, 2 read channel, 3 bus error
    function automatic int grp_of(input int t);
        case (t)
            0: return 0;
            3: return 3;
            1, 4, 5: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] m_rd(input logic s, input logic w, input logic [7:0] a);
        if (!s || w) return 32'h0;
        case (a)
            8'h00: return (m_mode == 1) ? 32'h5 : (m_mode == 2) ? 32'h7 : 32'h0;
            8'h04: return m_cfg;
            8'h08: return {31'b0, (m_mode == 2 && m_cnt == 0)};
            8'h14: return m_base;
            8'h18: return {24'b0, m_stat};
            8'h24: return m_cap[0];
            8'h28: return m_cap[1];
            8'h2C: return m_cap[2];
            8'h30: return m_cap[3];
            8'h34: return 32'h3000_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2 ctrl read";
            8'h08: return "R3 status read";
            8'h18: return "R4 int status read";
            8'h1C: return "R6 clear read";
            8'h0C, 8'h10: return "R9 flush read";
            8'h24, 8'h28, 8'h2C, 8'h30: return "R7 capture read";
            default: return "R10 register read";
        endcase
    endfunction

    // Reference model step at each rising edge
    always @(posedge clk) begin
        logic       wr, acc;
        logic [7:0] clr, pre;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_stat = '0;
            for (int g = 0; g < 4; g++) m_cap[g] = '0;
            m_cfg = '0; m_base = '0; m_fa = 0; m_fe = 0; m_page = '0;
        end else begin
            wr  = bus_sel && bus_wr;
            acc = flt_valid && (m_mode != 0);
            clr = (wr && bus_addr == 8'h1C) ? bus_wdata[7:0] : 8'h0;
            pre = m_stat & ~clr;
            if (acc) begin
                bit busy = 0;
                for (int i = 0; i < 8; i++)
                    if (pre[i] && grp_of(i) == grp_of(int'(flt_type))) busy = 1;
                if (!busy) m_cap[grp_of(int'(flt_type))] = flt_addr;
                pre[flt_type] = 1'b1;
            end
            m_stat = pre;
            if (acc) begin
                m_mode = 2; m_cnt = 0;
            end else if (wr && bus_addr == 8'h00 && bus_wdata == 32'h5) begin
                m_mode = 1; m_cnt = 0;
            end else if (wr && bus_addr == 8'h00 && bus_wdata == 32'h0) begin
                m_mode = 0; m_cnt = 0;
            end else if (wr && bus_addr == 8'h00 && bus_wdata == 32'h7 && m_mode != 2) begin
                m_mode = 2; m_cnt = 2;
            end else if (m_mode == 2 && m_cnt > 0) begin
                m_cnt--;
            end
            m_fa = wr && bus_addr == 8'h0C && bus_wdata[0];
            m_fe = wr && bus_addr == 8'h10 && bus_wdata[0];
            if (m_fe) m_page = bus_wdata[31:12];
            if (wr && bus_addr == 8'h04) m_cfg = bus_wdata;
            if (wr && bus_addr == 8'h14) m_base = bus_wdata;
        end
        started = 1;
    end

    // Compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R4 irq", irq, |m_stat);
            check("R3 stall", stall, m_mode == 2);
            check("R2 xlat_en", xlat_en, m_mode == 1);
            check("R9 flush_all", flush_all, m_fa);
            check("R9 flush_entry", flush_entry, m_fe);
            check("R9 flush_page", flush_page, m_page);
            check("R10 cfg_word", cfg_word, m_cfg);
            check("R10 tbl_base", tbl_base, m_base);
            check(tag_of(bus_addr), bus_rdata, m_rd(bus_sel, bus_wr, bus_addr));
        end
    end

    task automatic cyc(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic fv, input logic [2:0] ft, input logic [31:0] fa);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        flt_valid = fv; flt_type = ft; flt_addr = fa;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; flt_valid = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0, 3'd0, 32'h0);
    endtask

    task automatic flt(input logic [2:0] t, input logic [31:0] fa);
        cyc(0, 0, 8'h0, 32'h0, 1, t, fa);
    endtask

    task automatic idle();
        cyc(0, 0, 8'h0, 32'h0, 0, 3'd0, 32'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", irq, 0);
        check("R1 stall", stall, 0);
        check("R1 xlat_en", xlat_en, 0);
        check("R1 flush_all", flush_all, 0);
        rd_chk("R1 ctrl", 8'h00, 32'h0);
        rd_chk("R1 status", 8'h08, 32'h0);
        rd_chk("R1 int status", 8'h18, 32'h0);

        // R10: plain registers, version, unmapped
        wr(8'h04, 32'h0000_1001);
        wr(8'h14, 32'h4000_0000);
        rd_chk("R10 cfg", 8'h04, 32'h0000_1001);
        rd_chk("R10 base", 8'h14, 32'h4000_0000);
        rd_chk("R10 version", 8'h34, 32'h3000_0000);
        rd_chk("R10 unmapped", 8'h40, 32'h0);

        // R8: fault while off is ignored
        flt(3'd0, 32'h1111_0000);
        check("R8 irq", irq, 0);
        rd_chk("R8 int status", 8'h18, 32'h0);
        rd_chk("R8 page capture", 8'h24, 32'h0);
        rd_chk("R8 ctrl", 8'h00, 32'h0);

        // R2: run mode, invalid code ignored
        wr(8'h00, 32'h5);
        check("R2 xlat_en", xlat_en, 1);
        wr(8'h00, 32'h3);
        rd_chk("R2 ctrl after bad code", 8'h00, 32'h5);

        // R3: hold with two-edge drain
        wr(8'h00, 32'h7);
        check("R3 stall", stall, 1);
        rd_chk("R3 drain edge0", 8'h08, 32'h0);
        idle();
        rd_chk("R3 drain edge1", 8'h08, 32'h0);
        idle();
        rd_chk("R3 drain done", 8'h08, 32'h1);
        wr(8'h00, 32'h7);
        rd_chk("R3 repeat hold keeps done", 8'h08, 32'h1);
        wr(8'h00, 32'h5);
        check("R3 stall released", stall, 0);
        rd_chk("R3 status cleared", 8'h08, 32'h0);

        // R4/R5/R7: read-channel faults
        flt(3'd5, 32'hA000_1000);
        check("R4 irq", irq, 1);
        check("R5 stall", stall, 1);
        rd_chk("R5 hold done", 8'h08, 32'h1);
        rd_chk("R4 status", 8'h18, 32'h20);
        rd_chk("R7 read capture", 8'h2C, 32'hA000_1000);
        flt(3'd1, 32'hB000_2000);
        rd_chk("R4 status two bits", 8'h18, 32'h22);
        rd_chk("R7 first kept", 8'h2C, 32'hA000_1000);
        flt(3'd2, 32'hC000_3000);
        rd_chk("R7 write capture", 8'h28, 32'hC000_3000);

        // R6: clear and recapture
        wr(8'h1C, 32'h20);
        rd_chk("R6 clear bit5", 8'h18, 32'h06);
        rd_chk("R7 kept while bit1 set", 8'h2C, 32'hA000_1000);
        wr(8'h1C, 32'h02);
        flt(3'd4, 32'hD000_4000);
        rd_chk("R7 recapture", 8'h2C, 32'hD000_4000);
        cyc(1, 1, 8'h1C, 32'h10, 1, 3'd4, 32'hE000_5000);
        rd_chk("R6 set beats clear", 8'h18, 32'h14);
        rd_chk("R7 capture after same-cycle clear", 8'h2C, 32'hE000_5000);

        // R5: fault beats run write
        cyc(1, 1, 8'h00, 32'h5, 1, 3'd3, 32'hF000_6000);
        check("R5 stays held", stall, 1);
        check("R5 no translation", xlat_en, 0);
        rd_chk("R7 bus error capture", 8'h30, 32'hF000_6000);
        wr(8'h1C, 32'hFF);
        check("R6 irq dropped", irq, 0);
        rd_chk("R6 status empty", 8'h18, 32'h0);
        wr(8'h00, 32'h5);
        check("R2 resume", xlat_en, 1);

        // R9: flush commands
        wr(8'h0C, 32'h1);
        check("R9 flush_all pulse", flush_all, 1);
        idle();
        check("R9 flush_all ends", flush_all, 0);
        wr(8'h10, 32'h1234_5001);
        check("R9 flush_entry pulse", flush_entry, 1);
        check("R9 flush_page", flush_page, 20'h12345);
        wr(8'h0C, 32'h0);
        check("R9 no pulse with bit0 clear", flush_all, 0);
        rd_chk("R9 flush reads zero", 8'h10, 32'h0);

        // R2: off
        wr(8'h00, 32'h0);
        check("R2 off xlat", xlat_en, 0);
        check("R2 off stall", stall, 0);
        idle();
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule